// File: doc/BRIEF.md
# Quantized MLP Inference Engine

This block classifies one 28x28 grayscale image with a fixed integer network of 784 inputs, 16 hidden neurons and 10 outputs. A one-cycle start pulse latches the image index and runs a fixed schedule. First the hidden biases are loaded. Then all 784 pixels stream past the 16 hidden neurons, which work in parallel. ReLU is applied to the hidden sums. The output biases are loaded, the 16 activations run through the 10 output neurons in parallel, and the index of the largest logit is registered as the class.

The block owns no storage for images or weights. It drives read addresses into external synchronous memories that answer one cycle later, and the surrounding logic or bench fills those memories. A debug select routes any stored hidden activation to a 32-bit output. The done flag and the class code hold until the next accepted start or reset.

Top module: `mlp_engine`

## Requirements
- R1: An active-low reset clears the done flag, the class code and all stored hidden activations to zero, and returns the engine to idle; this applies in any phase.
- R2: A start pulse seen while idle launches one inference. Done drops on the cycle after the start is accepted, rises once when the class is registered, and then holds with the class code until the next accepted start.
- R3: A start pulse that arrives while an inference is running is ignored and does not change the result.
- R4: Hidden neuron j computes bias_j plus the sum over all pixels of pixel times weight. Pixels are unsigned 8-bit, weights are signed 8-bit, and the sum wraps in 32-bit two's complement. A negative sum is stored as zero (ReLU).
- R5: Output neuron k computes bias_k plus the sum over h of act_h times weight_hk, with no activation applied, so negative logits stay negative.
- R6: The class code is the index 0 to 9 of the largest logit under a signed compare; on equal logits the lowest index wins.
- R7: dbgAct always shows the stored ReLU activation of the hidden neuron chosen by dbgSel.
- R8: Memory reads have one cycle of latency. In a hidden weight word, neuron j sits at bits [8j+7:8j]. In an output weight word, neuron k sits at bits [8k+7:8k]. In a bias word, neuron n sits at bits [32n+31:32n]; biasRdLayer=0 selects the hidden biases and 1 selects the output biases, which use the low 10 words.
- R9: Pixel addresses run 0 to 783 in consecutive cycles, after which hidden addresses run 0 to 15.
- R10: The image index is sampled only when a start is accepted; a change on imgSel during a run has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse |
| imgSel | input | 4 | Image index sampled at start |
| dbgSel | input | 4 | Hidden neuron shown on dbgAct |
| imgRdImg | output | 4 | Image index to image memory |
| imgRdPix | output | 10 | Pixel address to image memory |
| imgRdData | input | 8 | Pixel, one cycle after the address |
| hwRdAddr | output | 10 | Hidden weight row address (pixel index) |
| hwRdData | input | 128 | 16 packed signed hidden weights |
| owRdAddr | output | 4 | Output weight row address (hidden index) |
| owRdData | input | 80 | 10 packed signed output weights |
| biasRdLayer | output | 1 | Bias word select, 0 hidden, 1 output |
| biasRdData | input | 512 | 16 packed 32-bit biases |
| done | output | 1 | Inference complete |
| classOut | output | 4 | Predicted class 0 to 9 |
| dbgAct | output | 32 | Selected hidden activation |

## Verification
The inline assertions check on every cycle that done is only high in idle, that done drops after an accepted start, that the image index does not move while busy, that pixel addresses advance by one, that a bias load lands in the accumulator, that activations are never negative, and that the class stays below ten. The arithmetic itself can only be shown by the bench's scenarios, which compare classes and hidden activations against an independent integer model. The same holds for tie breaking, linear negative logits, an all-zero hidden layer, ignored mid-run starts and a reset in mid-run.

// File: rtl/mlp_pkg.sv
package mlp_pkg;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_HBIAS,
    PH_HLOAD,
    PH_HMAC,
    PH_HDRAIN,
    PH_RELU,
    PH_OBIAS,
    PH_OLOAD,
    PH_OMAC,
    PH_ODRAIN,
    PH_ARGMAX,
    PH_FINISH
  } mlp_phase_t;

  typedef struct packed {
    logic loadBiasH;
    logic loadBiasO;
    logic issueH;
    logic issueO;
    logic relu;
    logic latchClass;
  } mlp_strobe_t;

endpackage

// File: rtl/mlp_mac.sv
module mlp_mac #(
  parameter int ACC_W = 32,
  parameter int W_W   = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             loadBias,
  input  logic [ACC_W-1:0] bias,
  input  logic             opValid,
  input  logic [ACC_W-1:0] operand,
  input  logic [W_W-1:0]   weight,
  output logic [ACC_W-1:0] acc
);

  localparam int FULL_W = ACC_W + W_W + 1;

  logic signed [FULL_W-1:0] fullProd;
  logic [ACC_W-1:0]         prodReg;
  logic                     prodValid;

  // operand is non-negative, weight is two's complement
  assign fullProd = $signed({1'b0, operand}) * $signed(weight);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prodReg   <= '0;
      prodValid <= 1'b0;
      acc       <= '0;
    end else begin
      prodValid <= opValid;
      if (opValid) prodReg <= fullProd[ACC_W-1:0];
      if (loadBias)       acc <= bias;
      else if (prodValid) acc <= acc + prodReg;
    end
  end

  AST_BIAS_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    loadBias |=> acc == $past(bias)); // R4

endmodule

// File: rtl/mlp_argmax.sv
module mlp_argmax #(
  parameter int NO    = 10,
  parameter int ACC_W = 32,
  localparam int CLS_W = (NO > 1) ? $clog2(NO) : 1
) (
  input  logic [NO-1:0][ACC_W-1:0] logits,
  output logic [CLS_W-1:0]         bestIdx
);

  logic [ACC_W-1:0] bestVal;

  always_comb begin
    bestIdx = '0;
    bestVal = logits[0];
    for (int k = 1; k < NO; k++) begin
      // strict compare keeps the lowest index on ties
      if ($signed(logits[k]) > $signed(bestVal)) begin
        bestIdx = CLS_W'(k);
        bestVal = logits[k];
      end
    end
  end

endmodule

// File: rtl/mlp_ctrl.sv
module mlp_ctrl
  import mlp_pkg::*;
#(
  parameter int NIN    = 784,
  parameter int NH     = 16,
  parameter int IMG_W  = 4,
  parameter int PIPE_LAT = 2,
  localparam int PIX_AW = $clog2(NIN)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [IMG_W-1:0]  imgSel,
  output mlp_strobe_t       strb,
  output logic [PIX_AW-1:0] cnt,
  output logic [IMG_W-1:0]  imgReg,
  output logic              biasRdLayer,
  output logic              done
);

  localparam logic [PIX_AW-1:0] LAST_PIX   = PIX_AW'(NIN - 1);
  localparam logic [PIX_AW-1:0] LAST_HID   = PIX_AW'(NH - 1);
  localparam logic [PIX_AW-1:0] LAST_DRAIN = PIX_AW'(PIPE_LAT - 1);

  mlp_phase_t phase;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase  <= PH_IDLE;
      cnt    <= '0;
      imgReg <= '0;
      done   <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (start) begin
            imgReg <= imgSel;
            done   <= 1'b0;
            phase  <= PH_HBIAS;
          end
        end
        PH_HBIAS: phase <= PH_HLOAD;
        PH_HLOAD: begin
          cnt   <= '0;
          phase <= PH_HMAC;
        end
        PH_HMAC: begin
          if (cnt == LAST_PIX) begin
            cnt   <= '0;
            phase <= PH_HDRAIN;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_HDRAIN: begin
          if (cnt == LAST_DRAIN) begin
            cnt   <= '0;
            phase <= PH_RELU;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_RELU:  phase <= PH_OBIAS;
        PH_OBIAS: phase <= PH_OLOAD;
        PH_OLOAD: begin
          cnt   <= '0;
          phase <= PH_OMAC;
        end
        PH_OMAC: begin
          if (cnt == LAST_HID) begin
            cnt   <= '0;
            phase <= PH_ODRAIN;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_ODRAIN: begin
          if (cnt == LAST_DRAIN) begin
            cnt   <= '0;
            phase <= PH_ARGMAX;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_ARGMAX: phase <= PH_FINISH;
        PH_FINISH: begin
          done  <= 1'b1;
          phase <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    strb            = '0;
    strb.loadBiasH  = (phase == PH_HLOAD);
    strb.loadBiasO  = (phase == PH_OLOAD);
    strb.issueH     = (phase == PH_HMAC);
    strb.issueO     = (phase == PH_OMAC);
    strb.relu       = (phase == PH_RELU);
    strb.latchClass = (phase == PH_ARGMAX);
  end

  assign biasRdLayer = (phase == PH_OBIAS);

  AST_DONE_IN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> phase == PH_IDLE); // R2
  AST_DONE_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_IDLE && start) |=> !done); // R2
  AST_BUSY_HOLDS_IMG: assert property (@(posedge clk) disable iff (!rstN)
    (phase != PH_IDLE) |=> $stable(imgReg)); // R3
  AST_PIX_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_HMAC && cnt != LAST_PIX) |=> (phase == PH_HMAC && cnt == $past(cnt) + 1'b1)); // R9

endmodule

// File: rtl/mlp_datapath.sv
module mlp_datapath
  import mlp_pkg::*;
#(
  parameter int NH    = 16,
  parameter int NO    = 10,
  parameter int W_W   = 8,
  parameter int PIX_W = 8,
  parameter int ACC_W = 32,
  localparam int HID_AW = $clog2(NH),
  localparam int CLS_W  = (NO > 1) ? $clog2(NO) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  mlp_strobe_t         strb,
  input  logic [HID_AW-1:0]   oIdx,
  input  logic [PIX_W-1:0]    imgRdData,
  input  logic [NH*W_W-1:0]   hwRdData,
  input  logic [NO*W_W-1:0]   owRdData,
  input  logic [NH*ACC_W-1:0] biasRdData,
  input  logic [HID_AW-1:0]   dbgSel,
  output logic [CLS_W-1:0]    classOut,
  output logic [ACC_W-1:0]    dbgAct
);

  logic                    validH, validO;
  logic [HID_AW-1:0]       idxD;
  logic [ACC_W-1:0]        hAcc [NH];
  logic [ACC_W-1:0]        act  [NH];
  logic [NO-1:0][ACC_W-1:0] oAcc;
  logic [ACC_W-1:0]        pixOp, actOp;
  logic [CLS_W-1:0]        bestIdx;

  // operands line up with memory data one cycle after the address
  always_ff @(posedge clk) begin
    if (!rstN) begin
      validH <= 1'b0;
      validO <= 1'b0;
      idxD   <= '0;
    end else begin
      validH <= strb.issueH;
      validO <= strb.issueO;
      idxD   <= oIdx;
    end
  end

  assign pixOp = {{(ACC_W-PIX_W){1'b0}}, imgRdData};
  assign actOp = act[idxD];

  for (genvar j = 0; j < NH; j++) begin : gHidden
    mlp_mac #(.ACC_W(ACC_W), .W_W(W_W)) uMac (
      .clk      (clk),
      .rstN     (rstN),
      .loadBias (strb.loadBiasH),
      .bias     (biasRdData[j*ACC_W +: ACC_W]),
      .opValid  (validH),
      .operand  (pixOp),
      .weight   (hwRdData[j*W_W +: W_W]),
      .acc      (hAcc[j])
    );

    AST_ACT_NONNEG: assert property (@(posedge clk) disable iff (!rstN)
      !act[j][ACC_W-1]); // R4
  end

  for (genvar k = 0; k < NO; k++) begin : gOutput
    mlp_mac #(.ACC_W(ACC_W), .W_W(W_W)) uMac (
      .clk      (clk),
      .rstN     (rstN),
      .loadBias (strb.loadBiasO),
      .bias     (biasRdData[k*ACC_W +: ACC_W]),
      .opValid  (validO),
      .operand  (actOp),
      .weight   (owRdData[k*W_W +: W_W]),
      .acc      (oAcc[k])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int j = 0; j < NH; j++) act[j] <= '0;
    end else if (strb.relu) begin
      for (int j = 0; j < NH; j++) act[j] <= hAcc[j][ACC_W-1] ? '0 : hAcc[j];
    end
  end

  mlp_argmax #(.NO(NO), .ACC_W(ACC_W)) uArgmax (
    .logits  (oAcc),
    .bestIdx (bestIdx)
  );

  always_ff @(posedge clk) begin
    if (!rstN)                classOut <= '0;
    else if (strb.latchClass) classOut <= bestIdx;
  end

  assign dbgAct = act[dbgSel];

  AST_CLASS_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    classOut <= CLS_W'(NO - 1)); // R6

endmodule

// File: rtl/mlp_engine.sv
module mlp_engine
  import mlp_pkg::*;
#(
  parameter int NIN   = 784,
  parameter int NH    = 16,
  parameter int NO    = 10,
  parameter int W_W   = 8,
  parameter int PIX_W = 8,
  parameter int ACC_W = 32,
  parameter int IMG_W = 4,
  localparam int PIX_AW = $clog2(NIN),
  localparam int HID_AW = $clog2(NH),
  localparam int CLS_W  = (NO > 1) ? $clog2(NO) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [IMG_W-1:0]    imgSel,
  input  logic [HID_AW-1:0]   dbgSel,
  output logic [IMG_W-1:0]    imgRdImg,
  output logic [PIX_AW-1:0]   imgRdPix,
  input  logic [PIX_W-1:0]    imgRdData,
  output logic [PIX_AW-1:0]   hwRdAddr,
  input  logic [NH*W_W-1:0]   hwRdData,
  output logic [HID_AW-1:0]   owRdAddr,
  input  logic [NO*W_W-1:0]   owRdData,
  output logic                biasRdLayer,
  input  logic [NH*ACC_W-1:0] biasRdData,
  output logic                done,
  output logic [CLS_W-1:0]    classOut,
  output logic [ACC_W-1:0]    dbgAct
);

  mlp_strobe_t       strb;
  logic [PIX_AW-1:0] cnt;

  mlp_ctrl #(.NIN(NIN), .NH(NH), .IMG_W(IMG_W)) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .start       (start),
    .imgSel      (imgSel),
    .strb        (strb),
    .cnt         (cnt),
    .imgReg      (imgRdImg),
    .biasRdLayer (biasRdLayer),
    .done        (done)
  );

  assign imgRdPix = cnt;
  assign hwRdAddr = cnt;
  assign owRdAddr = cnt[HID_AW-1:0];

  mlp_datapath #(
    .NH(NH), .NO(NO), .W_W(W_W), .PIX_W(PIX_W), .ACC_W(ACC_W)
  ) uDatapath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .oIdx       (cnt[HID_AW-1:0]),
    .imgRdData  (imgRdData),
    .hwRdData   (hwRdData),
    .owRdData   (owRdData),
    .biasRdData (biasRdData),
    .dbgSel     (dbgSel),
    .classOut   (classOut),
    .dbgAct     (dbgAct)
  );

endmodule

// File: tb/mlp_engine_test.sv
`timescale 1ns/1ps
module mlp_engine_test;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [3:0]   imgSel = '0;
  logic [3:0]   dbgSel = '0;
  logic [3:0]   imgRdImg;
  logic [9:0]   imgRdPix;
  logic [7:0]   imgRdData = '0;
  logic [9:0]   hwRdAddr;
  logic [127:0] hwRdData = '0;
  logic [3:0]   owRdAddr;
  logic [79:0]  owRdData = '0;
  logic         biasRdLayer;
  logic [511:0] biasRdData = '0;
  logic         done;
  logic [3:0]   classOut;
  logic [31:0]  dbgAct;

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;
  int hMode   = 0;
  int oMode   = 0;
  int expAct [16];
  int expLogit [10];
  int expCls;

  always #10 clk = ~clk;

  mlp_engine uut (
    .clk(clk), .rstN(rstN), .start(start), .imgSel(imgSel), .dbgSel(dbgSel),
    .imgRdImg(imgRdImg), .imgRdPix(imgRdPix), .imgRdData(imgRdData),
    .hwRdAddr(hwRdAddr), .hwRdData(hwRdData), .owRdAddr(owRdAddr),
    .owRdData(owRdData), .biasRdLayer(biasRdLayer), .biasRdData(biasRdData),
    .done(done), .classOut(classOut), .dbgAct(dbgAct)
  );

  // memory contents as functions of the address
  function automatic int pixF(int img, int p);
    if ((p + img * 7) % 5 == 0) return 0;
    return (img * 53 + p * 29 + (p / 28) * (p % 28)) % 256;
  endfunction

  function automatic int hwF(int p, int j);
    return ((p * 17 + j * 31 + (p * j) % 13) % 256) - 128;
  endfunction

  function automatic int owF(int h, int k);
    if (oMode != 0) return 0;
    return ((h * 7 + k * 11 + 3) % 32) - 16;
  endfunction

  function automatic int hbF(int j);
    if (hMode != 0) return -100000000;
    return j * 1000 - 8000;
  endfunction

  function automatic int obF(int k);
    case (oMode)
      1: return 5;
      2: return (k == 9) ? 100 : k;
      3: return (k == 3 || k == 7) ? 50 : 0;
      4: return (k == 6) ? -5 : -1000 - k;
      default: return k * 3 - 10;
    endcase
  endfunction

  // one-cycle-latency read ports (R8)
  always @(posedge clk) begin
    imgRdData <= 8'(pixF(int'(imgRdImg), int'(imgRdPix)));
    for (int j = 0; j < 16; j++) begin
      hwRdData[j*8 +: 8] <= 8'(hwF(int'(hwRdAddr), j));
      biasRdData[j*32 +: 32] <= biasRdLayer ? ((j < 10) ? obF(j) : 0) : hbF(j);
    end
    for (int k = 0; k < 10; k++) owRdData[k*8 +: 8] <= 8'(owF(int'(owRdAddr), k));
  end

  task automatic computeExpected(input int img);
    for (int j = 0; j < 16; j++) begin
      int a = hbF(j);
      for (int p = 0; p < 784; p++) a += pixF(img, p) * hwF(p, j);
      expAct[j] = (a < 0) ? 0 : a;
    end
    for (int k = 0; k < 10; k++) begin
      int l = obF(k);
      for (int h = 0; h < 16; h++) l += expAct[h] * owF(h, k);
      expLogit[k] = l;
    end
    expCls = 0;
    for (int k = 1; k < 10; k++) if (expLogit[k] > expLogit[expCls]) expCls = k;
  endtask

  task automatic chk(input string req, input int actual, input int expected);
    vectors++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic pulseStart(input int img);
    @(negedge clk);
    imgSel = 4'(img);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitDone();
    while (!done) @(negedge clk);
  endtask

  task automatic runOne(input int img);
    pulseStart(img);
    chk("R2 done low after start", int'(done), 0);
    waitDone();
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      finishRun();
    end
  end

  // stimulus table: {image index, debug neuron}
  localparam logic [7:0] VEC [8] = '{
    8'h00, 8'h13, 8'h27, 8'h5A, 8'h8F, 8'hB1, 8'hE4, 8'hFC
  };

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 done at reset", int'(done), 0);
    chk("R1 class at reset", int'(classOut), 0);
    chk("R1 act at reset", int'(dbgAct), 0);
    rstN = 1'b1;

    for (int v = 0; v < 8; v++) begin
      int img = int'(VEC[v][7:4]);
      dbgSel = VEC[v][3:0];
      computeExpected(img);
      runOne(img);
      chk("R6/R5/R8/R9 class", int'(classOut), expCls);
      chk("R7/R4 debug act", int'(dbgAct), expAct[int'(VEC[v][3:0])]);
    end

    // R4 and R7: sweep every hidden activation of the last image
    for (int j = 0; j < 16; j++) begin
      dbgSel = 4'(j);
      @(negedge clk);
      chk("R4 hidden act sweep", int'(dbgAct), expAct[j]);
    end

    // R2 result holds while idle
    repeat (40) @(negedge clk);
    chk("R2 done holds", int'(done), 1);
    chk("R2 class holds", int'(classOut), expCls);

    // R3 and R10: mid-run start and image change are ignored
    computeExpected(3);
    pulseStart(3);
    repeat (60) @(negedge clk);
    imgSel = 4'd9;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitDone();
    chk("R3/R10 busy start ignored", int'(classOut), expCls);
    dbgSel = 4'd5;
    @(negedge clk);
    chk("R10 image latched", int'(dbgAct), expAct[5]);

    // R4 all hidden sums negative, R5 linear negative logits
    hMode = 1;
    oMode = 4;
    computeExpected(2);
    runOne(2);
    for (int j = 0; j < 16; j++) begin
      dbgSel = 4'(j);
      @(negedge clk);
      chk("R4 relu clamps", int'(dbgAct), 0);
    end
    chk("R5 negative logits kept", int'(classOut), 6);

    // R6 ties and boundaries
    hMode = 0;
    oMode = 1;
    runOne(4);
    chk("R6 all tie lowest", int'(classOut), 0);
    oMode = 3;
    runOne(4);
    chk("R6 tie 3 and 7", int'(classOut), 3);
    oMode = 2;
    runOne(4);
    chk("R6 max at last index", int'(classOut), 9);

    // R1 reset in mid-run, then R2 recovery
    oMode = 0;
    pulseStart(7);
    repeat (200) @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R1 mid-run done", int'(done), 0);
    chk("R1 mid-run class", int'(classOut), 0);
    chk("R1 mid-run act", int'(dbgAct), 0);
    rstN = 1'b1;
    computeExpected(7);
    runOne(7);
    chk("R2 run after reset", int'(classOut), expCls);

    finishRun();
  end

endmodule